// File: doc/BRIEF.md
# Receive Special-Character Flow Controller

This block sits on the receive side of one serial channel, between the character deserialiser and the receive FIFO. Each received character is compared against four programmable special characters. The block reports which one matched and runs in-band XON/XOFF flow control for the channel's transmitter. It also decides which characters go on to the receive FIFO. Flow-control characters are either consumed or, in transparent mode, passed on.

XON and XOFF can each be a single character, or a two-character sequence. As a sequence, XON is character 1 followed by character 3, and XOFF is character 2 followed by character 4. While the block waits for the second character of a sequence, it holds the first one back. If the sequence breaks, the held character comes out on a separate flush port, in the same cycle as the character that broke it. The FIFO writes the flush port first.

An implied-XON mode lets any received character restart a transmitter that XOFF has stopped. All outputs are registered. They reflect a received character one clock after its strobe.

Top module: `rx_flowctl`

## Requirements
- R1: `match_code` reports each received character as follows: 3'b000 no match, 3'b001 character 1 (or the XON pair), 3'b010 character 2 (or the XOFF pair), 3'b011 character 3, 3'b100 character 4.
- R2: With `xon_pair` set, XON is recognised only as character 1 immediately followed by character 3. Character 1 alone yields code 000 and is held back.
- R3: With `xoff_pair` set, XOFF is recognised only as character 2 immediately followed by character 4. Character 2 alone yields code 000 and is held back.
- R4: A recognised XOFF clears `tx_permit`, sets `flow_off` and clears `flow_on`.
- R5: A recognised XON sets `tx_permit` and `flow_on`, and clears `flow_off`.
- R6: With `xon_implied` set, any received character other than an XOFF restarts a stopped transmitter (`tx_permit`=1, `flow_on`=1, `flow_off`=0). Without it, ordinary characters leave a stopped transmitter stopped.
- R7: Recognised XON/XOFF characters are consumed (`fwd_vld`=0) unless `fc_transp` is set, in which case they are forwarded. Characters 3 and 4, when not completing a pair, are always forwarded.
- R8: Unless both `det_en` and `inband_en` are set, every character is forwarded with code 000, and the flow state does not change.
- R9: When a held first character of a pair is not followed by its partner, it is emitted on `flush_vld`/`flush_data`. The breaking character is then processed afresh, and may itself start a new pair.
- R10: After reset, `tx_permit`=1, `flow_on`=1, `flow_off`=0, `match_code`=000, and no valid pulses are output.
- R11: When one received value equals several special characters, the lowest-numbered character wins.
- R12: Outputs change one clock after `rx_vld`. `fwd_vld` and `flush_vld` are one-cycle pulses. `match_code` and the flow state hold between characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | 1 | Received-character strobe |
| rx_data | input | DATA_W | Received character |
| sc_char1 | input | DATA_W | Special character 1 (XON, or XON first) |
| sc_char2 | input | DATA_W | Special character 2 (XOFF, or XOFF first) |
| sc_char3 | input | DATA_W | Special character 3 (XON second) |
| sc_char4 | input | DATA_W | Special character 4 (XOFF second) |
| det_en | input | 1 | Special-character detection enable |
| inband_en | input | 1 | In-band flow-control enable |
| xon_pair | input | 1 | XON is a two-character sequence |
| xoff_pair | input | 1 | XOFF is a two-character sequence |
| fc_transp | input | 1 | Forward flow-control characters |
| xon_implied | input | 1 | Any character restarts the transmitter |
| match_code | output | 3 | Match code of the last character |
| tx_permit | output | 1 | Transmitter may send |
| flow_on | output | 1 | Last flow event was XON |
| flow_off | output | 1 | Last flow event was XOFF |
| flush_vld | output | 1 | Held pair character released as data |
| flush_data | output | DATA_W | Released held character |
| fwd_vld | output | 1 | Current character goes to the FIFO |
| fwd_data | output | DATA_W | Current character |

## Verification
The bench breaks pair sequences in two ways: with ordinary data, and with a repeated first character. A design that dropped the held character, or failed to restart the pair, would lose data or miss the XON that follows.

It checks that a stopped transmitter stays stopped on ordinary data unless implied-XON is on. A design that resumed unconditionally would defeat XOFF.

It checks that flow characters are swallowed or passed through according to the transparency bit. Duplicated register values probe the match priority.

Disabled detection must leave data untouched even when the data equals a flow character.

// File: rtl/rx_flowctl_pkg.sv
package rx_flowctl_pkg;

    localparam int CHAR_W = 8;
    localparam int NUM_SC = 4;

    typedef enum logic [2:0] {
        MC_NONE = 3'd0,
        MC_SC1  = 3'd1,
        MC_SC2  = 3'd2,
        MC_SC3  = 3'd3,
        MC_SC4  = 3'd4
    } match_code_e;

    typedef enum logic [1:0] {
        FE_NONE,
        FE_XON,
        FE_XOFF,
        FE_RESUME
    } flow_ev_e;

    typedef enum logic {
        PK_XON,
        PK_XOFF
    } pend_kind_e;

    typedef struct packed {
        match_code_e code;
        flow_ev_e    ev;
        logic        fwd;
        logic        flush;
        logic        start;
        pend_kind_e  kind;
    } decision_t;

    function automatic match_code_e pair_code(pend_kind_e k);
        return (k == PK_XON) ? MC_SC1 : MC_SC2;
    endfunction

    function automatic flow_ev_e pair_event(pend_kind_e k);
        return (k == PK_XON) ? FE_XON : FE_XOFF;
    endfunction

endpackage

// File: rtl/sc_cmp.sv
module sc_cmp #(
    parameter int DATA_W = 8,
    parameter int NUM_SC = 4
) (
    input  logic [DATA_W-1:0]             rx_data,
    input  logic [NUM_SC-1:0][DATA_W-1:0] refs,
    output logic [NUM_SC-1:0]             eq
);
    for (genvar g = 0; g < NUM_SC; g++) begin : g_cmp
        assign eq[g] = (rx_data == refs[g]);
    end
endmodule

// File: rtl/sc_flow_state.sv
module sc_flow_state
    import rx_flowctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  flow_ev_e ev,
    output logic     tx_permit,
    output logic     flow_on,
    output logic     flow_off
);
    logic on_q, off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q  <= 1'b1;
            off_q <= 1'b0;
        end else begin
            unique case (ev)
                FE_XOFF:   begin on_q <= 1'b0; off_q <= 1'b1; end
                FE_XON:    begin on_q <= 1'b1; off_q <= 1'b0; end
                FE_RESUME: if (off_q) begin on_q <= 1'b1; off_q <= 1'b0; end
                default:   ;
            endcase
        end
    end

    assign tx_permit = ~off_q;
    assign flow_on   = on_q;
    assign flow_off  = off_q;

    // R5
    xon_sets_on_chk: assert property (@(posedge clk) disable iff (rst)
        ev == FE_XON |=> flow_on && !flow_off && tx_permit);

    // R6
    resume_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        ev == FE_RESUME |=> tx_permit && flow_on);
endmodule

// File: rtl/rx_flowctl.sv
module rx_flowctl
    import rx_flowctl_pkg::*;
#(
    parameter int DATA_W = CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_vld,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [DATA_W-1:0] sc_char1,
    input  logic [DATA_W-1:0] sc_char2,
    input  logic [DATA_W-1:0] sc_char3,
    input  logic [DATA_W-1:0] sc_char4,
    input  logic              det_en,
    input  logic              inband_en,
    input  logic              xon_pair,
    input  logic              xoff_pair,
    input  logic              fc_transp,
    input  logic              xon_implied,
    output logic [2:0]        match_code,
    output logic              tx_permit,
    output logic              flow_on,
    output logic              flow_off,
    output logic              flush_vld,
    output logic [DATA_W-1:0] flush_data,
    output logic              fwd_vld,
    output logic [DATA_W-1:0] fwd_data
);
    localparam int SC_N = NUM_SC;

    logic [SC_N-1:0][DATA_W-1:0] refs;
    logic [SC_N-1:0]             eq;
    logic                        act;
    logic                        pend_hit;
    decision_t                   dec;
    flow_ev_e                    ev_in;

    logic              pend_vld;
    pend_kind_e        pend_kind;
    logic              pend_fwd;
    logic [DATA_W-1:0] pend_data;
    match_code_e       code_q;

    assign refs = {sc_char4, sc_char3, sc_char2, sc_char1};

    sc_cmp #(.DATA_W(DATA_W), .NUM_SC(SC_N)) u_cmp (
        .rx_data (rx_data),
        .refs    (refs),
        .eq      (eq)
    );

    assign act      = det_en & inband_en;
    assign pend_hit = act & pend_vld &
                      (((pend_kind == PK_XON)  & eq[2]) |
                       ((pend_kind == PK_XOFF) & eq[3]));

    always_comb begin
        dec = '{code: MC_NONE, ev: FE_NONE, fwd: 1'b1, flush: 1'b0,
                start: 1'b0, kind: PK_XON};
        if (pend_hit) begin
            dec.code = pair_code(pend_kind);
            dec.ev   = pair_event(pend_kind);
            dec.fwd  = fc_transp;
        end else begin
            dec.flush = pend_vld & ~pend_fwd;
            if (act) begin
                if (eq[0]) begin
                    dec.fwd = fc_transp;
                    if (xon_pair) begin
                        dec.start = 1'b1;
                        dec.kind  = PK_XON;
                    end else begin
                        dec.code = MC_SC1;
                        dec.ev   = FE_XON;
                    end
                end else if (eq[1]) begin
                    dec.fwd = fc_transp;
                    if (xoff_pair) begin
                        dec.start = 1'b1;
                        dec.kind  = PK_XOFF;
                    end else begin
                        dec.code = MC_SC2;
                        dec.ev   = FE_XOFF;
                    end
                end else if (eq[2]) begin
                    dec.code = MC_SC3;
                end else if (eq[3]) begin
                    dec.code = MC_SC4;
                end
            end
        end
        if (act && xon_implied && dec.ev == FE_NONE)
            dec.ev = FE_RESUME;
    end

    assign ev_in = rx_vld ? dec.ev : FE_NONE;

    sc_flow_state u_flow (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev_in),
        .tx_permit (tx_permit),
        .flow_on   (flow_on),
        .flow_off  (flow_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q     <= MC_NONE;
            fwd_vld    <= 1'b0;
            fwd_data   <= '0;
            flush_vld  <= 1'b0;
            flush_data <= '0;
            pend_vld   <= 1'b0;
            pend_kind  <= PK_XON;
            pend_fwd   <= 1'b0;
            pend_data  <= '0;
        end else if (rx_vld) begin
            code_q     <= dec.code;
            fwd_vld    <= dec.fwd;
            fwd_data   <= rx_data;
            flush_vld  <= dec.flush;
            flush_data <= pend_data;
            pend_vld   <= dec.start;
            pend_kind  <= dec.kind;
            pend_fwd   <= fc_transp;
            pend_data  <= rx_data;
        end else begin
            fwd_vld   <= 1'b0;
            flush_vld <= 1'b0;
        end
    end

    assign match_code = code_q;

    // R4
    xoff_stops_chk: assert property (@(posedge clk) disable iff (rst)
        rx_vld && dec.ev == FE_XOFF |=> !tx_permit && flow_off && !flow_on);

    // R8
    disabled_passes_chk: assert property (@(posedge clk) disable iff (rst)
        rx_vld && !act && !pend_vld |=> fwd_vld && match_code == 3'd0 &&
            fwd_data == $past(rx_data) && $stable(tx_permit));

    // R9
    flush_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        flush_vld |-> $past(pend_vld));

    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> tx_permit && flow_on && !flow_off &&
            match_code == 3'd0 && !fwd_vld && !flush_vld);

    // R12
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_vld |=> !fwd_vld && !flush_vld && $stable(tx_permit) &&
            $stable(match_code));

    // R1
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        match_code <= 3'd4);
endmodule

// File: tb/test_rx_flowctl.sv
module test_rx_flowctl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    localparam logic [DW-1:0] C1 = 8'h11, C2 = 8'h13, C3 = 8'h21, C4 = 8'h23;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_vld = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic [DW-1:0] sc1 = C1, sc2 = C2, sc3 = C3, sc4 = C4;
    logic det_en = 1'b0, inband_en = 1'b0, xon_pair = 1'b0, xoff_pair = 1'b0;
    logic fc_transp = 1'b0, xon_implied = 1'b0;
    logic [2:0] match_code;
    logic tx_permit, flow_on, flow_off, flush_vld, fwd_vld;
    logic [DW-1:0] flush_data, fwd_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_flowctl i_rx_flowctl (
        .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_data(rx_data),
        .sc_char1(sc1), .sc_char2(sc2), .sc_char3(sc3), .sc_char4(sc4),
        .det_en(det_en), .inband_en(inband_en), .xon_pair(xon_pair),
        .xoff_pair(xoff_pair), .fc_transp(fc_transp), .xon_implied(xon_implied),
        .match_code(match_code), .tx_permit(tx_permit), .flow_on(flow_on),
        .flow_off(flow_off), .flush_vld(flush_vld), .flush_data(flush_data),
        .fwd_vld(fwd_vld), .fwd_data(fwd_data)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Drive one character on a falling edge; return on the next falling edge.
    task automatic send(logic [DW-1:0] d);
        rx_vld  = 1'b1;
        rx_data = d;
        @(negedge clk);
        rx_vld  = 1'b0;
    endtask

    task automatic chk_flow(string req, logic on_exp);
        chk({req, " tx_permit"}, tx_permit, on_exp);
        chk({req, " flow_on"}, flow_on, on_exp);
        chk({req, " flow_off"}, flow_off, !on_exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk_flow("R10 reset", 1'b1);
        chk("R10 code", match_code, 3'd0);
        chk("R10 fwd_vld", fwd_vld, 1'b0);
        chk("R10 flush_vld", flush_vld, 1'b0);
    endtask

    task automatic t_disabled();
        det_en = 1'b0; inband_en = 1'b1;
        send(C2);
        chk("R8 code det off", match_code, 3'd0);
        chk("R8 fwd det off", fwd_vld, 1'b1);
        chk("R8 data det off", fwd_data, C2);
        chk_flow("R8 flow det off", 1'b1);
        det_en = 1'b1; inband_en = 1'b0;
        send(C2);
        chk("R8 code ib off", match_code, 3'd0);
        chk("R8 fwd ib off", fwd_vld, 1'b1);
        chk_flow("R8 flow ib off", 1'b1);
    endtask

    task automatic t_single();
        do_reset();
        det_en = 1'b1; inband_en = 1'b1; fc_transp = 1'b0;
        xon_pair = 1'b0; xoff_pair = 1'b0; xon_implied = 1'b0;
        send(8'h41);
        chk("R1 plain code", match_code, 3'd0);
        chk("R7 plain fwd", fwd_vld, 1'b1);
        send(C2);
        chk("R1 xoff code", match_code, 3'd2);
        chk("R7 xoff consumed", fwd_vld, 1'b0);
        chk_flow("R4 xoff", 1'b0);
        send(8'h41);
        chk_flow("R6 no implied", 1'b0);
        send(C3);
        chk("R1 sc3 code", match_code, 3'd3);
        chk("R7 sc3 fwd", fwd_vld, 1'b1);
        chk("R7 sc3 data", fwd_data, C3);
        send(C4);
        chk("R1 sc4 code", match_code, 3'd4);
        chk("R7 sc4 fwd", fwd_vld, 1'b1);
        send(C1);
        chk("R1 xon code", match_code, 3'd1);
        chk("R7 xon consumed", fwd_vld, 1'b0);
        chk_flow("R5 xon", 1'b1);
        @(negedge clk);
        chk("R12 code held", match_code, 3'd1);
        chk("R12 fwd pulse", fwd_vld, 1'b0);
    endtask

    task automatic t_transp();
        fc_transp = 1'b1;
        send(C2);
        chk("R7 transp xoff fwd", fwd_vld, 1'b1);
        chk("R7 transp xoff data", fwd_data, C2);
        chk("R1 transp xoff code", match_code, 3'd2);
        chk_flow("R4 transp xoff", 1'b0);
        send(C1);
        chk("R7 transp xon fwd", fwd_vld, 1'b1);
        chk_flow("R5 transp xon", 1'b1);
        fc_transp = 1'b0;
    endtask

    task automatic t_implied();
        xon_implied = 1'b1;
        send(C2);
        chk_flow("R6 stop", 1'b0);
        send(8'h55);
        chk_flow("R6 implied resume", 1'b1);
        chk("R6 resume fwd", fwd_vld, 1'b1);
        chk("R6 resume code", match_code, 3'd0);
        xon_implied = 1'b0;
    endtask

    task automatic t_pairs();
        xon_pair = 1'b1; xoff_pair = 1'b1;
        send(C2);
        chk("R3 held code", match_code, 3'd0);
        chk("R3 held fwd", fwd_vld, 1'b0);
        chk_flow("R3 not yet", 1'b1);
        send(C4);
        chk("R3 pair code", match_code, 3'd2);
        chk("R3 pair fwd", fwd_vld, 1'b0);
        chk("R3 pair flush", flush_vld, 1'b0);
        chk_flow("R3 pair xoff", 1'b0);
        send(C1);
        chk("R2 held code", match_code, 3'd0);
        chk_flow("R2 not yet", 1'b0);
        send(C3);
        chk("R2 pair code", match_code, 3'd1);
        chk_flow("R2 pair xon", 1'b1);
    endtask

    task automatic t_partial();
        send(C1);
        send(8'h55);
        chk("R9 flush vld", flush_vld, 1'b1);
        chk("R9 flush data", flush_data, C1);
        chk("R9 cur fwd", fwd_vld, 1'b1);
        chk("R9 cur data", fwd_data, 8'h55);
        chk("R9 code", match_code, 3'd0);
        send(C2);
        send(C4);
        chk_flow("R9 xoff", 1'b0);
        send(C1);
        send(C1);
        chk("R9 dup flush", flush_vld, 1'b1);
        chk("R9 dup flush data", flush_data, C1);
        chk("R9 dup held", fwd_vld, 1'b0);
        send(C3);
        chk("R9 restart code", match_code, 3'd1);
        chk("R9 restart flush", flush_vld, 1'b0);
        chk_flow("R9 restart xon", 1'b1);
        send(C4);
        chk("R3 lone sc4 code", match_code, 3'd4);
        chk("R3 lone sc4 fwd", fwd_vld, 1'b1);
        xon_pair = 1'b0; xoff_pair = 1'b0;
    endtask

    task automatic t_priority();
        sc3 = C1; sc4 = C2;
        send(C1);
        chk("R11 sc1 over sc3", match_code, 3'd1);
        send(C2);
        chk("R11 sc2 over sc4", match_code, 3'd2);
        chk_flow("R11 xoff", 1'b0);
        sc3 = C3; sc4 = C4;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_disabled();
        t_single();
        t_transp();
        t_implied();
        t_pairs();
        t_partial();
        t_priority();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule